// File: doc/BRIEF.md
# Reference Code Selector with Digital Soft-Start

This block turns a two-bit setpoint code into a reference word in millivolts and walks the live reference toward that word one millivolt at a time. When the block is enabled, the live reference starts at zero and climbs to the selected level. A completion flag rises once the climb has landed. If the code changes later, the reference slews to the new level instead of jumping.

An external override word can replace the table level. It is clamped to a ceiling first. For start-up into an output that is already charged, the block takes a sample of the output level on the enable cycle. It holds its low-side permission output low until the rising reference has caught up with that sample, so the converter never discharges the load.

Either select bit may be marked as floating. A floating bit reads as its pulled-up default. Dropping the enable or the supply-good input returns everything to zero on the next clock edge.

Top module: `refsel_softstart`

## Requirements
- R1: The effective code maps to the target level as 00 = 600 mV, 01 = 900 mV, 10 = 1200 mV and 11 = 1500 mV. Bit 0 of the code is `sel_i[0]`.
- R2: A select bit whose `sel_float_i` bit is 1 reads as the parameter default (2'b11 by default), bit by bit. With `sel_i` = 00, a float mask of 11 gives 1500 mV and a float mask of 01 gives 900 mV.
- R3: Start-up begins from `ref_mv_o` = 0. The edge that first samples `enable_i` and `por_ok_i` both high is counted as edge 0. The reference then rises by exactly 1 per step and equals k after edge k·STEP_DIV.
- R4: `ss_done_o` stays low while the reference climbs. It rises on the same edge on which `ref_mv_o` first equals the target, which is edge target·STEP_DIV.
- R5: After start-up has completed, a code change moves `ref_mv_o` by at most 1 per edge, at one step per STEP_DIV edges, up or down to the new level. `ss_done_o` stays high throughout.
- R6: `prebias_mv_i` is sampled on edge 0. `lowside_en_o` is low on edge 0. On each later edge it becomes 1 if the reference held before that edge was at least the sample, or if start-up has completed. Once set, it stays 1 until the block is disabled.
- R7: When `ext_sel_i` is 1, the target is `ext_mv_i` limited to at most 1750 mV. A request of 2000 ends at 1750, and a request of 1000 ends at 1000.
- R8: On any edge that samples `enable_i` or `por_ok_i` low, the reference goes to 0 and `ss_done_o` and `lowside_en_o` go to 0.
- R9: While `rst_n` is low, and after its release with the block disabled, the reference, `ss_done_o` and `lowside_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable |
| por_ok_i | input | 1 | Supply-good flag |
| sel_i | input | 2 | Setpoint code |
| sel_float_i | input | 2 | Per-bit flag: select bit left undriven |
| ext_sel_i | input | 1 | Use the external override word |
| ext_mv_i | input | MV_W | External override level, mV |
| prebias_mv_i | input | MV_W | Sampled output level, mV |
| ref_mv_o | output | MV_W | Live reference, mV |
| ss_done_o | output | 1 | Start-up completed |
| lowside_en_o | output | 1 | Low-side switching permitted |

## Verification
The properties assume that the code, the float mask and the override inputs change only while the block is disabled or after completion. Under that assumption, the target a completion edge compares against is the one the step logic saw. The directed stimulus keeps to this rule. It changes these inputs at the falling clock edge and only between whole ramps, or once `ss_done_o` is already high. The pre-bias sample is held steady across each ramp, so the low-side gate is judged against a single value.

// File: rtl/refss_pkg.sv
package refss_pkg;

  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RAMP = 2'd1,
    SS_RUN  = 2'd2
  } ss_state_e;

  // Level for a two-bit code: base plus code times spacing.
  function automatic int unsigned code_to_mv(input logic [1:0] code,
                                             input int unsigned base_mv,
                                             input int unsigned step_mv);
    return base_mv + step_mv * {30'd0, code};
  endfunction

endpackage

// File: rtl/refss_code_map.sv
module refss_code_map
  import refss_pkg::*;
#(
  parameter int unsigned MV_W         = 12,
  parameter int unsigned BASE_MV      = 600,
  parameter int unsigned CODE_STEP_MV = 300,
  parameter int unsigned EXT_MAX_MV   = 1750,
  parameter logic [1:0]  SEL_DFLT     = 2'b11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel_i,
  input  logic [1:0]      sel_float_i,
  input  logic            ext_sel_i,
  input  logic [MV_W-1:0] ext_mv_i,
  output logic [MV_W-1:0] target_mv_o
);

  localparam logic [MV_W-1:0] EXT_MAX    = MV_W'(EXT_MAX_MV);
  localparam logic [MV_W-1:0] RST_TARGET = MV_W'(code_to_mv(SEL_DFLT, BASE_MV, CODE_STEP_MV));

  logic [1:0]      code_eff;
  logic [MV_W-1:0] table_mv;
  logic [MV_W-1:0] ext_lim;
  logic [MV_W-1:0] target_nxt;
  logic [MV_W-1:0] target_q;

  // An undriven select bit reads as its pulled-up default.
  for (genvar b = 0; b < 2; b++) begin : g_bit
    assign code_eff[b] = sel_float_i[b] ? SEL_DFLT[b] : sel_i[b];
  end

  always_comb begin
    table_mv   = MV_W'(code_to_mv(code_eff, BASE_MV, CODE_STEP_MV));
    ext_lim    = (ext_mv_i > EXT_MAX) ? EXT_MAX : ext_mv_i;
    target_nxt = ext_sel_i ? ext_lim : table_mv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) target_q <= RST_TARGET;
    else        target_q <= target_nxt;
  end

  assign target_mv_o = target_q;

endmodule

// File: rtl/refss_tick.sv
module refss_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (!run_i)    cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign tick_o = run_i && wrap;

endmodule

// File: rtl/refss_slew.sv
module refss_slew #(
  parameter int unsigned MV_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [MV_W-1:0] target_i,
  output logic [MV_W-1:0] ref_o,
  output logic [MV_W-1:0] ref_nxt_o
);

  localparam logic [MV_W-1:0] ONE = MV_W'(1);

  logic [MV_W-1:0] ref_q;
  logic [MV_W-1:0] ref_nxt;

  always_comb begin
    ref_nxt = ref_q;
    if (clr_i) begin
      ref_nxt = '0;
    end else if (step_i) begin
      if (ref_q < target_i)      ref_nxt = ref_q + ONE;
      else if (ref_q > target_i) ref_nxt = ref_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_nxt;
  end

  assign ref_o     = ref_q;
  assign ref_nxt_o = ref_nxt;

endmodule

// File: rtl/refss_ctrl.sv
module refss_ctrl
  import refss_pkg::*;
#(
  parameter int unsigned MV_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active_i,
  input  logic [MV_W-1:0] ref_i,
  input  logic [MV_W-1:0] ref_nxt_i,
  input  logic [MV_W-1:0] target_i,
  input  logic [MV_W-1:0] prebias_i,
  output logic            run_o,
  output logic            done_o,
  output logic            lowside_o,
  output logic [MV_W-1:0] pb_o
);

  ss_state_e       state_q, state_nxt;
  logic [MV_W-1:0] pb_q, pb_nxt;
  logic            ls_q, ls_nxt;

  always_comb begin
    state_nxt = state_q;
    pb_nxt    = pb_q;
    ls_nxt    = ls_q;
    if (!active_i) begin
      state_nxt = SS_IDLE;
      ls_nxt    = 1'b0;
    end else begin
      unique case (state_q)
        SS_IDLE: begin
          state_nxt = SS_RAMP;
          pb_nxt    = prebias_i;
          ls_nxt    = 1'b0;
        end
        SS_RAMP: begin
          if (ref_nxt_i == target_i) state_nxt = SS_RUN;
          if (ref_i >= pb_q)         ls_nxt    = 1'b1;
        end
        SS_RUN:  ls_nxt = 1'b1;
        default: state_nxt = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SS_IDLE;
      pb_q    <= '0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_nxt;
      pb_q    <= pb_nxt;
      ls_q    <= ls_nxt;
    end
  end

  assign run_o     = active_i && (state_q != SS_IDLE);
  assign done_o    = (state_q == SS_RUN);
  assign lowside_o = ls_q;
  assign pb_o      = pb_q;

endmodule

// File: rtl/refsel_softstart.sv
module refsel_softstart #(
  parameter int unsigned MV_W         = 12,
  parameter int unsigned BASE_MV      = 600,
  parameter int unsigned CODE_STEP_MV = 300,
  parameter int unsigned EXT_MAX_MV   = 1750,
  parameter int unsigned STEP_DIV     = 4,
  parameter logic [1:0]  SEL_DFLT     = 2'b11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic            por_ok_i,
  input  logic [1:0]      sel_i,
  input  logic [1:0]      sel_float_i,
  input  logic            ext_sel_i,
  input  logic [MV_W-1:0] ext_mv_i,
  input  logic [MV_W-1:0] prebias_mv_i,
  output logic [MV_W-1:0] ref_mv_o,
  output logic            ss_done_o,
  output logic            lowside_en_o
);

  logic            active;
  logic            run;
  logic            tick;
  logic [MV_W-1:0] target_mv;
  logic [MV_W-1:0] ref_nxt;
  logic [MV_W-1:0] pb_mv;

  assign active = enable_i && por_ok_i;

  refss_code_map #(
    .MV_W(MV_W), .BASE_MV(BASE_MV), .CODE_STEP_MV(CODE_STEP_MV),
    .EXT_MAX_MV(EXT_MAX_MV), .SEL_DFLT(SEL_DFLT)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .sel_float_i(sel_float_i),
    .ext_sel_i(ext_sel_i), .ext_mv_i(ext_mv_i), .target_mv_o(target_mv)
  );

  refss_tick #(.DIV(STEP_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_o(tick)
  );

  refss_slew #(.MV_W(MV_W)) u_slew (
    .clk(clk), .rst_n(rst_n), .clr_i(!active), .step_i(tick),
    .target_i(target_mv), .ref_o(ref_mv_o), .ref_nxt_o(ref_nxt)
  );

  refss_ctrl #(.MV_W(MV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .active_i(active), .ref_i(ref_mv_o),
    .ref_nxt_i(ref_nxt), .target_i(target_mv), .prebias_i(prebias_mv_i),
    .run_o(run), .done_o(ss_done_o), .lowside_o(lowside_en_o), .pb_o(pb_mv)
  );

endmodule

// File: rtl/refsel_softstart_chk.sv
module refsel_softstart_chk #(
  parameter int unsigned MV_W       = 12,
  parameter int unsigned EXT_MAX_MV = 1750
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable_i,
  input logic            por_ok_i,
  input logic [MV_W-1:0] ref_mv,
  input logic            ss_done,
  input logic            lowside_en,
  input logic [MV_W-1:0] target_mv,
  input logic [MV_W-1:0] pb_mv
);

  localparam logic [MV_W-1:0] ONE     = MV_W'(1);
  localparam logic [MV_W-1:0] CEILING = MV_W'(EXT_MAX_MV);

  // R8: a disabled edge zeroes every output
  assert_loss_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable_i && por_ok_i) |=> (ref_mv == '0) && !ss_done && !lowside_en);

  // R3 and R5: the reference never moves more than one step per edge
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && por_ok_i) |=> (ref_mv == $past(ref_mv)) ||
                               (ref_mv == $past(ref_mv) + ONE) ||
                               ($past(ref_mv) == ref_mv + ONE));

  // R4: completion lands exactly on the target
  assert_done_on_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_done) |-> (ref_mv == $past(target_mv)));

  // R5: completion holds while enabled
  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_done && enable_i && por_ok_i) |=> ss_done);

  // R6: low side opens only after catching the pre-bias or finishing
  assert_lowside_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowside_en) |-> ($past(ref_mv) >= $past(pb_mv)) || $past(ss_done));

  // R7: the reference never exceeds the override ceiling
  assert_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_mv <= CEILING);

endmodule

bind refsel_softstart refsel_softstart_chk #(
  .MV_W(MV_W), .EXT_MAX_MV(EXT_MAX_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .por_ok_i(por_ok_i),
  .ref_mv(ref_mv_o), .ss_done(ss_done_o), .lowside_en(lowside_en_o),
  .target_mv(target_mv), .pb_mv(pb_mv)
);

// File: tb/tb_refsel_softstart.sv
module tb_refsel_softstart;

  localparam int MV_W = 12;
  localparam int DIV  = 4;

  logic            clk;
  logic            rst_n;
  logic            enable_i;
  logic            por_ok_i;
  logic [1:0]      sel_i;
  logic [1:0]      sel_float_i;
  logic            ext_sel_i;
  logic [MV_W-1:0] ext_mv_i;
  logic [MV_W-1:0] prebias_mv_i;
  logic [MV_W-1:0] ref_mv_o;
  logic            ss_done_o;
  logic            lowside_en_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  refsel_softstart #(.MV_W(MV_W), .STEP_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .por_ok_i(por_ok_i),
    .sel_i(sel_i), .sel_float_i(sel_float_i), .ext_sel_i(ext_sel_i),
    .ext_mv_i(ext_mv_i), .prebias_mv_i(prebias_mv_i), .ref_mv_o(ref_mv_o),
    .ss_done_o(ss_done_o), .lowside_en_o(lowside_en_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable_i = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  // Enable, follow the climb edge by edge, stop at completion.
  task automatic ramp(input int tgt, input int pb, input string req);
    int n = 0;
    int prev = 0;
    bit exp_ls = 1'b0;
    int step_err = 0;
    int ls_err = 0;
    bit stop = 1'b0;
    prebias_mv_i = MV_W'(pb);
    @(negedge clk);
    enable_i = 1'b1;
    while (!stop) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n > 1) exp_ls = exp_ls || (prev >= pb);
      if (lowside_en_o !== exp_ls) ls_err++;
      if ((int'(ref_mv_o) - prev) != 0 && (int'(ref_mv_o) - prev) != 1) step_err++;
      if (ss_done_o || n > tgt * DIV + 50) stop = 1'b1;
      prev = int'(ref_mv_o);
    end
    chk(n == tgt * DIV + 1, {req, " R3 R4 completion edge"}, n, tgt * DIV + 1);
    chk(int'(ref_mv_o) == tgt, {req, " R1 final level"}, int'(ref_mv_o), tgt);
    chk(step_err == 0, {req, " R3 unit steps"}, step_err, 0);
    chk(ls_err == 0, {req, " R6 low-side gate"}, ls_err, 0);
  endtask

  // Follow a slew after a code change while running.
  task automatic slew_to(input int tgt, input int delta, input string req);
    int n = 0;
    int prev = int'(ref_mv_o);
    int err = 0;
    bit stop = 1'b0;
    while (!stop) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (!ss_done_o) err++;
      if ((int'(ref_mv_o) - prev) > 1 || (prev - int'(ref_mv_o)) > 1) err++;
      prev = int'(ref_mv_o);
      if (prev == tgt || n > delta * DIV + 50) stop = 1'b1;
    end
    chk(prev == tgt, {req, " R5 slew level"}, prev, tgt);
    chk(n >= (delta - 1) * DIV + 1 && n <= delta * DIV + 1, {req, " R5 slew duration"}, n, delta * DIV);
    chk(err == 0, {req, " R5 done held, unit steps"}, err, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable_i = 1'b0; por_ok_i = 1'b1;
    sel_i = 2'b00; sel_float_i = 2'b00; ext_sel_i = 1'b0;
    ext_mv_i = '0; prebias_mv_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ref_mv_o == '0 && !ss_done_o && !lowside_en_o, "R9 in reset",
        int'(ref_mv_o) + int'(ss_done_o) + int'(lowside_en_o), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(ref_mv_o == '0 && !ss_done_o && !lowside_en_o, "R9 after release",
        int'(ref_mv_o) + int'(ss_done_o) + int'(lowside_en_o), 0);
  endtask

  task automatic t_table();
    for (int c = 0; c < 4; c++) begin
      go_idle();
      sel_i = 2'(c);
      ramp(600 + 300 * c, 0, "R1 code");
    end
  endtask

  task automatic t_float();
    go_idle();
    sel_i = 2'b00; sel_float_i = 2'b11;
    ramp(1500, 0, "R2 both floating");
    go_idle();
    sel_float_i = 2'b01;
    ramp(900, 0, "R2 bit0 floating");
    sel_float_i = 2'b00;
  endtask

  task automatic t_prebias();
    go_idle();
    sel_i = 2'b10;
    ramp(1200, 700, "R6 prebias 700");
    prebias_mv_i = '0;
  endtask

  task automatic t_ext();
    go_idle();
    ext_sel_i = 1'b1; ext_mv_i = 12'd2000;
    ramp(1750, 0, "R7 clamp 2000");
    go_idle();
    ext_mv_i = 12'd1000;
    ramp(1000, 0, "R7 pass 1000");
    ext_sel_i = 1'b0;
  endtask

  task automatic t_slew();
    go_idle();
    sel_i = 2'b00;
    ramp(600, 0, "R5 base");
    @(negedge clk);
    sel_i = 2'b01;
    slew_to(900, 300, "R5 up");
    @(negedge clk);
    sel_i = 2'b00;
    slew_to(600, 300, "R5 down");
  endtask

  task automatic t_loss();
    go_idle();
    sel_i = 2'b11;
    @(negedge clk);
    enable_i = 1'b1;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(!ss_done_o, "R4 not done mid-ramp", int'(ss_done_o), 0);
    chk(ref_mv_o != '0, "R3 climbing", int'(ref_mv_o), 24);
    por_ok_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(ref_mv_o == '0 && !ss_done_o && !lowside_en_o, "R8 supply loss",
        int'(ref_mv_o) + int'(ss_done_o) + int'(lowside_en_o), 0);
    por_ok_i = 1'b1;
    go_idle();
    sel_i = 2'b00;
    ramp(600, 0, "R8 rerun");
    @(negedge clk);
    enable_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(ref_mv_o == '0 && !ss_done_o && !lowside_en_o, "R8 enable loss",
        int'(ref_mv_o) + int'(ss_done_o) + int'(lowside_en_o), 0);
  endtask

  initial begin
    t_reset();
    t_table();
    t_float();
    t_prebias();
    t_ext();
    t_slew();
    t_loss();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule